// File: doc/BRIEF.md
# Reset Source Controller with Supply Monitor

This block sequences the reset of a small microcontroller core. Four requests can put the core into reset: a power-on indication, an undervoltage comparator on the supply (only when the supply monitor is enabled), a low level on the external reset pin, and a software request made through a register write. The block produces one active-high core reset and an open-drain style drive enable for the active-low reset pin. It also presents a constant restart vector of zero, because every source makes the core start again at the same address.

A small cause register tells software why the last reset happened. It holds a power-on flag and one flag for each other source. Bit 1 has two meanings. When read, it is the power-on flag. When written with 1, it turns the supply monitor on. Only a power-on reset turns the monitor off again. Only a power-on reset adds a programmable release delay. The cause register is loaded one cycle before the core leaves reset, so the core's first read already sees stable flags.

The power-on indication is an asynchronous reset for all of the block's state. The comparators and the voltage thresholds are outside the block and reach it as digital inputs.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_req_i` is high, `core_rst_o` and `rst_pin_oe_o` are 1 and `reg_rdata_o` is 0. After `por_req_i` falls, `core_rst_o` stays 1 for exactly POR_CYCLES+1 rising edges and is 0 after that. `rst_pin_oe_o` is never 1 while `core_rst_o` is 0.
- R2: A power-on reset disables the supply monitor. A register write with bit 1 set, made while the core runs, enables it. A write with bit 1 clear does not disable it, and no reset other than power-on disables it.
- R3: While the monitor is disabled, `vdd_low_i` has no effect on `core_rst_o`.
- R4: If the monitor is enabled and `vdd_low_i` is 1 at an edge while the core runs, `core_rst_o` and `rst_pin_oe_o` are 1 from that edge on. They stay 1 while `vdd_low_i` stays 1. `core_rst_o` falls on the second edge after `vdd_low_i` returns to 0, with no power-on delay. The cause register then reads 0x04 (bit 2), with the power-on flag cleared.
- R5: An external low on the reset pin passes two synchroniser flops. `core_rst_o` rises on the third edge after the pin goes low, and `rst_pin_oe_o` stays 0 while the pin is held low. `core_rst_o` falls on the fourth edge after the pin returns high, and the cause register then reads 0x01 (bit 0).
- R6: A register write with bit 4 set, made while the core runs, holds `core_rst_o` at 1 for exactly two cycles and drives `rst_pin_oe_o`. The cause register then reads 0x10 (bit 4).
- R7: The cause register takes its new value on the edge one cycle before `core_rst_o` falls, and it keeps that value across the release. After power-on it reads 0x02 (bit 1).
- R8: Writes to bit positions other than 1 and 4 are ignored. Every write made while `core_rst_o` is 1 is ignored.
- R9: The block's own low drive on the reset pin, as it is read back after a release, is never taken as an external reset.
- R10: `restart_vec_o` is zero at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_req_i | input | 1 | Power-on indication, active high, asynchronous |
| vdd_low_i | input | 1 | Supply undervoltage comparator output, synchronous |
| rst_pin_i | input | 1 | Level read back from the active-low reset pin |
| rst_pin_oe_o | output | 1 | Drives the reset pin low when 1 |
| core_rst_o | output | 1 | Core reset, active high |
| restart_vec_o | output | VEC_W | Address the core restarts from |
| reg_we_i | input | 1 | Cause register write strobe |
| reg_wdata_i | input | 8 | Write data: bit 1 enables the monitor, bit 4 requests software reset |
| reg_rdata_o | output | 8 | Cause flags: bit 0 pin, bit 1 power-on, bit 2 monitor, bit 4 software |

## Verification
The assertions assume that `vdd_low_i` is already synchronous to `clk`, and that writes come only from a core that is running. They also assume that the pin read back is the wired combination of the block's own drive and any outside drive. The bench models the pin this way, as an AND of the two drives. It changes every input one time unit after a rising edge. It sweeps the undervoltage hold length over several values, and it issues writes both while the core runs and during a power-on hold.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN   = 2'd0,
    SEQ_HOLD  = 2'd1,
    SEQ_LATCH = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    SRC_POR = 2'd0,
    SRC_MON = 2'd1,
    SRC_PIN = 2'd2,
    SRC_SW  = 2'd3
  } rst_src_t;

  localparam int REG_W       = 8;
  localparam int BIT_PIN     = 0;
  localparam int BIT_POR     = 1;
  localparam int BIT_MON     = 2;
  localparam int BIT_SW      = 4;

  // Flag word recorded for a given reset source.
  function automatic logic [REG_W-1:0] cause_word(input rst_src_t src);
    logic [REG_W-1:0] w;
    w = '0;
    case (src)
      SRC_POR: w[BIT_POR] = 1'b1;
      SRC_MON: w[BIT_MON] = 1'b1;
      SRC_PIN: w[BIT_PIN] = 1'b1;
      default: w[BIT_SW]  = 1'b1;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or posedge arst) begin
        if (arst) chain_q[g] <= 1'b1;
        else      chain_q[g] <= (g == 0) ? d_i : chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_por_timer.sv
module rst_por_timer #(
  parameter int CYCLES = 7500
) (
  input  logic clk,
  input  logic arst,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic at_end(input logic [CNT_W-1:0] c);
    return c == LAST;
  endfunction

  always_ff @(posedge clk or posedge arst) begin
    if (arst)                     cnt_q <= '0;
    else if (run_i && !at_end(cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = at_end(cnt_q);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             arst,
  input  logic             load_i,
  input  rst_src_t         src_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] flags_o,
  output logic             mon_en_o
);
  logic [REG_W-1:0] flags_q;
  logic             mon_en_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      flags_q  <= '0;
      mon_en_q <= 1'b0;
    end else begin
      if (load_i) flags_q <= cause_word(src_i);
      if (wr_i && wdata_i[BIT_POR]) mon_en_q <= 1'b1;
    end
  end

  assign flags_o  = flags_q;
  assign mon_en_o = mon_en_q;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int POR_CYCLES  = 7500,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 16
) (
  input  logic             clk,
  input  logic             por_req_i,
  input  logic             vdd_low_i,
  input  logic             rst_pin_i,
  output logic             rst_pin_oe_o,
  output logic             core_rst_o,
  output logic [VEC_W-1:0] restart_vec_o,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o
);
  localparam logic [VEC_W-1:0] RESTART_ADDR = '0;

  seq_state_t           state_q;
  rst_src_t             src_q;
  logic [SYNC_STAGES-1:0] oe_hist_q;

  logic pin_low_s;
  logic por_done_w;
  logic mon_en_w;
  logic hold_w;
  logic mon_trip_w;
  logic ext_trip_w;
  logic sw_trip_w;
  logic in_latch_w;
  logic load_w;
  logic wr_ok_w;
  logic pin_sync_w;
  logic oe_w;

  rst_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk  (clk),
    .arst (por_req_i),
    .d_i  (rst_pin_i),
    .q_o  (pin_sync_w)
  );
  assign pin_low_s = ~pin_sync_w;

  rst_por_timer #(.CYCLES(POR_CYCLES)) u_por_timer (
    .clk    (clk),
    .arst   (por_req_i),
    .run_i  (state_q == SEQ_HOLD && src_q == SRC_POR),
    .done_o (por_done_w)
  );

  // Reset requests seen while the core runs; monitor wins, then pin, then software.
  assign wr_ok_w    = reg_we_i && (state_q == SEQ_RUN);
  assign mon_trip_w = mon_en_w && vdd_low_i;
  assign ext_trip_w = pin_low_s && !oe_w && !(|oe_hist_q);
  assign sw_trip_w  = wr_ok_w && reg_wdata_i[BIT_SW];

  always_comb begin
    case (src_q)
      SRC_POR: hold_w = !por_done_w;
      SRC_MON: hold_w = vdd_low_i;
      SRC_PIN: hold_w = pin_low_s;
      default: hold_w = 1'b0;
    endcase
  end

  assign load_w     = (state_q == SEQ_HOLD) && !hold_w;
  assign in_latch_w = (state_q == SEQ_LATCH);

  always_ff @(posedge clk or posedge por_req_i) begin
    if (por_req_i) begin
      state_q   <= SEQ_HOLD;
      src_q     <= SRC_POR;
      oe_hist_q <= '1;
    end else begin
      oe_hist_q <= {oe_hist_q[SYNC_STAGES-2:0], oe_w};
      case (state_q)
        SEQ_RUN: begin
          if (mon_trip_w) begin
            state_q <= SEQ_HOLD;
            src_q   <= SRC_MON;
          end else if (ext_trip_w) begin
            state_q <= SEQ_HOLD;
            src_q   <= SRC_PIN;
          end else if (sw_trip_w) begin
            state_q <= SEQ_HOLD;
            src_q   <= SRC_SW;
          end
        end
        SEQ_HOLD:  if (!hold_w) state_q <= SEQ_LATCH;
        default:   state_q <= SEQ_RUN;
      endcase
    end
  end

  rst_cause_reg u_cause (
    .clk      (clk),
    .arst     (por_req_i),
    .load_i   (load_w),
    .src_i    (src_q),
    .wr_i     (wr_ok_w),
    .wdata_i  (reg_wdata_i),
    .flags_o  (reg_rdata_o),
    .mon_en_o (mon_en_w)
  );

  // The pin is left alone while an outside agent already holds it low.
  assign oe_w          = (state_q != SEQ_RUN) && !(state_q == SEQ_HOLD && src_q == SRC_PIN);
  assign rst_pin_oe_o  = oe_w;
  assign core_rst_o    = (state_q != SEQ_RUN);
  assign restart_vec_o = RESTART_ADDR;
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk (
  input logic       clk,
  input logic       por_req_i,
  input logic       vdd_low_i,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic       core_rst_o,
  input logic       rst_pin_oe_o,
  input logic [7:0] reg_rdata_o,
  input logic       mon_en_w,
  input logic       ext_trip_w,
  input logic       in_latch_w
);
  p_oe_in_reset_r1: assert property (@(posedge clk) disable iff (por_req_i)
    rst_pin_oe_o |-> core_rst_o);

  p_mon_sticky_r2: assert property (@(posedge clk) disable iff (por_req_i)
    mon_en_w |=> mon_en_w);

  p_mon_off_quiet_r3: assert property (@(posedge clk) disable iff (por_req_i)
    !mon_en_w && !core_rst_o && !ext_trip_w && !(reg_we_i && reg_wdata_i[4]) |=> !core_rst_o);

  p_mon_trip_r4: assert property (@(posedge clk) disable iff (por_req_i)
    mon_en_w && vdd_low_i && !core_rst_o |=> core_rst_o && rst_pin_oe_o);

  p_sw_trip_r6: assert property (@(posedge clk) disable iff (por_req_i)
    !core_rst_o && reg_we_i && reg_wdata_i[4] |=> core_rst_o);

  p_flags_before_release_r7: assert property (@(posedge clk) disable iff (por_req_i)
    in_latch_w |=> !core_rst_o && $stable(reg_rdata_o));
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk u_chk (
  .clk          (clk),
  .por_req_i    (por_req_i),
  .vdd_low_i    (vdd_low_i),
  .reg_we_i     (reg_we_i),
  .reg_wdata_i  (reg_wdata_i),
  .core_rst_o   (core_rst_o),
  .rst_pin_oe_o (rst_pin_oe_o),
  .reg_rdata_o  (reg_rdata_o),
  .mon_en_w     (mon_en_w),
  .ext_trip_w   (ext_trip_w),
  .in_latch_w   (in_latch_w)
);

// File: tb/rst_seq_ctrl_bench.sv
`timescale 1ns/1ps
module rst_seq_ctrl_bench;
  localparam int N     = 8;
  localparam int VEC_W = 16;

  logic clk = 1'b0;
  logic por_req = 1'b1;
  logic vdd_low = 1'b0;
  logic ext_low = 1'b0;
  logic we = 1'b0;
  logic [7:0] wdata = '0;
  logic pin, oe, core_rst;
  logic [VEC_W-1:0] vec;
  logic [7:0] rdata;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign pin = ~(oe | ext_low);

  rst_seq_ctrl #(.POR_CYCLES(N), .SYNC_STAGES(2), .VEC_W(VEC_W)) u_rst_seq_ctrl (
    .clk           (clk),
    .por_req_i     (por_req),
    .vdd_low_i     (vdd_low),
    .rst_pin_i     (pin),
    .rst_pin_oe_o  (oe),
    .core_rst_o    (core_rst),
    .restart_vec_o (vec),
    .reg_we_i      (we),
    .reg_wdata_i   (wdata),
    .reg_rdata_o   (rdata)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] d);
    we = 1'b1; wdata = d;
    step(1);
    we = 1'b0; wdata = '0;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 core_rst in por", core_rst, 1);
    chk("R1 oe in por", oe, 1);
    chk("R1 rdata in por", rdata, 0);
    chk("R10 vector", vec, 0);
    por_req = 1'b0;
    step(N - 1);
    chk("R1 still held", core_rst, 1);
    chk("R7 flags not yet loaded", rdata, 0);
    step(1);
    chk("R7 flags before release", rdata, 8'h02);
    chk("R7 still in reset", core_rst, 1);
    step(1);
    chk("R1 released after N+1", core_rst, 0);
    chk("R7 flags kept", rdata, 8'h02);
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk("R9 own drive not external", core_rst, 0);
    end

    // R3: monitor disabled
    vdd_low = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(1);
      chk("R3 monitor off", core_rst, 0);
    end
    vdd_low = 1'b0;

    // R8: other bits ignored
    reg_write(8'hED);
    chk("R8 rdata unchanged", rdata, 8'h02);
    chk("R8 no reset", core_rst, 0);
    vdd_low = 1'b1;
    step(2);
    chk("R8 monitor not enabled", core_rst, 0);
    vdd_low = 1'b0;
    step(1);

    // R2/R4: enable monitor, sweep hold length
    reg_write(8'h02);
    chk("R2 read still power-on flag", rdata, 8'h02);
    for (int len = 1; len <= 6; len++) begin
      vdd_low = 1'b1;
      for (int k = 0; k < len; k++) begin
        step(1);
        chk("R4 held during low", core_rst, 1);
        chk("R4 pin driven", oe, 1);
      end
      vdd_low = 1'b0;
      step(1);
      chk("R4 latch cycle", core_rst, 1);
      chk("R4 monitor flag", rdata, 8'h04);
      step(1);
      chk("R4 release no delay", core_rst, 0);
      chk("R10 vector", vec, 0);
      step(4);
    end

    // R6: software reset
    reg_write(8'h10);
    chk("R6 reset cycle 1", core_rst, 1);
    chk("R6 pin driven", oe, 1);
    step(1);
    chk("R6 reset cycle 2", core_rst, 1);
    chk("R6 sw flag", rdata, 8'h10);
    step(1);
    chk("R6 released", core_rst, 0);
    step(4);

    // R2: zero write keeps enable, survives sw reset
    reg_write(8'h00);
    vdd_low = 1'b1;
    step(1);
    chk("R2 monitor still enabled", core_rst, 1);
    vdd_low = 1'b0;
    step(2);
    chk("R2 released", core_rst, 0);
    step(4);

    // R5: external pin reset
    ext_low = 1'b1;
    step(2);
    chk("R5 not yet", core_rst, 0);
    step(1);
    chk("R5 asserted third edge", core_rst, 1);
    chk("R5 pin not driven", oe, 0);
    step(3);
    chk("R5 held", core_rst, 1);
    chk("R5 pin still not driven", oe, 0);
    ext_low = 1'b0;
    step(2);
    chk("R5 held after release", core_rst, 1);
    step(1);
    chk("R5 pin flag", rdata, 8'h01);
    chk("R5 latch", core_rst, 1);
    step(1);
    chk("R5 released", core_rst, 0);
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk("R9 no false pin reset", core_rst, 0);
    end

    // R1/R2/R8: power-on clears enable, writes in reset ignored
    por_req = 1'b1;
    step(1);
    chk("R1 por again", core_rst, 1);
    chk("R1 rdata cleared", rdata, 0);
    por_req = 1'b0;
    we = 1'b1; wdata = 8'h12;
    step(N + 1);
    we = 1'b0; wdata = '0;
    chk("R8 writes in reset ignored", core_rst, 0);
    chk("R7 power-on flag", rdata, 8'h02);
    step(4);
    vdd_low = 1'b1;
    step(3);
    chk("R2 monitor disabled by por", core_rst, 0);
    vdd_low = 1'b0;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule